// File: doc/BRIEF.md
# Paced Multi-Channel DMA Request Scheduler

This block picks which DMA channel issues the next bus transfer. Each channel has a 6-bit pacing selector. The selector ties the channel to one of 59 external data-request lines, to one of up to four internal timer strobes, or to a permanent request. Every pulse on the selected source adds one unit to a per-channel credit. An enabled channel that has work pending becomes eligible when it holds credit, or at once when it runs unpaced.

Arbitration works in rounds. Within a round, each eligible high-priority channel is served once, lowest index first. After that, a single low-priority channel receives the one low slot of the round, chosen round-robin. The scheduler then starts the next round. When no channel of one class is eligible, the other class takes the slot, so a low-priority channel on an idle scheduler is granted on every cycle. Priority only orders the issue of grants. The surrounding bus logic raises `ready_i` in each cycle that it can accept a transfer and performs the transfer for the channel that was granted.

Top module: `dma_pace_sched`

## Requirements
- R1: Selector values 0 to 58 (0x00 to 0x3A) select the external request line with the same number. A pulse on any other line or timer adds no credit.
- R2: Selector values 59 to 62 (0x3B to 0x3E) select timer strobes 0 to 3. When the selector names a timer index at or above N_TIMER, the channel never gains credit.
- R3: Selector value 63 (0x3F) makes the channel unpaced. Such a channel is eligible without credit, and its grants leave its stored credit unchanged.
- R4: The credit is a 6-bit counter that saturates at 63. It rises by one for each pulse received while the channel is enabled and falls by one for each paced grant. A paced channel is eligible only while its credit is nonzero.
- R5: A channel whose enable is low receives no grant, ignores its pulses and keeps its credit. When it is enabled again, it resumes with that credit.
- R6: Within a round, each eligible high-priority channel is granted once, lowest index first. Exactly one low-priority grant then closes the round. When no low-priority channel is eligible, a new round starts with the high-priority set.
- R7: The low-priority slot is given round-robin. The search starts at the index after the last low-priority channel granted; after reset it starts at channel 0.
- R8: A grant is issued in every cycle in which `ready_i` is high and at least one channel is eligible. No grant is issued while `ready_i` is low.
- R9: `gnt_o` has at most one bit set. While `gnt_valid_o` is high, `gnt_o` equals one shifted left by `gnt_idx_o`.
- R10: A channel whose work flag is low is not granted, whatever its credit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dreq_i | input | N_DREQ | External data-request pulses |
| timer_i | input | N_TIMER | Internal timer strobes |
| ch_en_i | input | N_CH | Per-channel enable |
| ch_hi_i | input | N_CH | Per-channel high-priority flag |
| ch_work_i | input | N_CH | Channel has transfers pending |
| ch_sel_i | input | N_CH*6 | Pacing selectors, channel c in bits [6c+5:6c] |
| ready_i | input | 1 | Bus can take a transfer this cycle |
| gnt_o | output | N_CH | One-hot grant, combinational in the cycle of issue |
| gnt_idx_o | output | $clog2(N_CH) | Index of the granted channel |
| gnt_valid_o | output | 1 | A grant is issued this cycle |

## Verification
The round assertions assume that the priority flags stay stable across the two cycles they compare. The credit assertions assume that a grant reaches only an eligible channel. The stimulus changes the flags only while the channels concerned are disabled or during reset, and lets grants come only from the scheduler. The selector sweep applies pulses one cycle at a time while `ready_i` is low, so each pulse is counted before any grant can consume it. Timers 2 and 3 are exercised against a second instance that has only two timers.

// File: rtl/dma_sched_pkg.sv
package dma_sched_pkg;
  localparam int SEL_W    = 6;
  localparam int SRC_N    = 1 << SEL_W;
  localparam int TMR_BASE = 59;
  localparam int TMR_MAX  = 4;
  localparam logic [SEL_W-1:0] SEL_UNPACED = 6'h3F;

  typedef logic [SEL_W-1:0] pace_sel_t;

  typedef enum logic [1:0] {
    PICK_NONE,
    PICK_HI,
    PICK_LO,
    PICK_RESTART
  } pick_e;
endpackage

// File: rtl/dma_pace_decode.sv
module dma_pace_decode
  import dma_sched_pkg::*;
#(
  parameter int N_DREQ  = 59,
  parameter int N_TIMER = 4
) (
  input  logic [N_DREQ-1:0]  dreq_i,
  input  logic [N_TIMER-1:0] timer_i,
  input  pace_sel_t          sel_i,
  output logic               pulse_o,
  output logic               unpaced_o
);
  logic [SRC_N-1:0] src;

  // absent timers and the unpaced code read as a constant zero source
  for (genvar i = 0; i < SRC_N; i++) begin : g_src
    if (i < N_DREQ) begin : g_dreq
      assign src[i] = dreq_i[i];
    end else if (i >= TMR_BASE && i < TMR_BASE + N_TIMER) begin : g_tmr
      assign src[i] = timer_i[i-TMR_BASE];
    end else begin : g_none
      assign src[i] = 1'b0;
    end
  end

  assign unpaced_o = (sel_i == SEL_UNPACED);
  assign pulse_o   = src[sel_i];
endmodule

// File: rtl/dma_pace_credit.sv
module dma_pace_credit #(
  parameter int CNT_W = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic work_i,
  input  logic pulse_i,
  input  logic unpaced_i,
  input  logic gnt_i,
  output logic elig_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic inc, dec;

  assign inc = en_i & pulse_i & (cnt_q != CNT_MAX);
  assign dec = gnt_i & ~unpaced_i;

  always_comb begin
    cnt_d = cnt_q;
    if (inc && !dec) cnt_d = cnt_q + 1'b1;
    else if (dec && !inc) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign elig_o = en_i & work_i & (unpaced_i | (cnt_q != '0));

  // R4
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX && !gnt_i) |=> cnt_q == CNT_MAX);
  // R4
  drop_only_on_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gnt_i |=> cnt_q >= $past(cnt_q));
  // R5
  paused_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> cnt_q == $past(cnt_q));
  // R3
  unpaced_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_i && unpaced_i) |=> cnt_q >= $past(cnt_q));
endmodule

// File: rtl/dma_round_arb.sv
module dma_round_arb
  import dma_sched_pkg::*;
#(
  parameter int N_CH = 8,
  localparam int IDX_W = $clog2(N_CH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_CH-1:0]  elig_i,
  input  logic [N_CH-1:0]  hi_i,
  input  logic             ready_i,
  output logic [N_CH-1:0]  gnt_o,
  output logic [IDX_W-1:0] gnt_idx_o,
  output logic             gnt_valid_o
);
  logic [N_CH-1:0]  served_q, cand_hi, elig_hi, elig_lo;
  logic [IDX_W-1:0] lo_ptr_q, lo_idx, sel_idx;
  logic             lo_found;
  pick_e            pick;

  function automatic logic [IDX_W-1:0] lowest(input logic [N_CH-1:0] v);
    lowest = '0;
    for (int i = N_CH - 1; i >= 0; i--) if (v[i]) lowest = IDX_W'(i);
  endfunction

  assign elig_hi = elig_i & hi_i;
  assign elig_lo = elig_i & ~hi_i;
  assign cand_hi = elig_hi & ~served_q;

  // round-robin search starting after the last low grant
  always_comb begin
    int j;
    lo_idx   = '0;
    lo_found = 1'b0;
    for (int k = 1; k <= N_CH; k++) begin
      j = int'(lo_ptr_q) + k;
      if (j >= N_CH) j = j - N_CH;
      if (!lo_found && elig_lo[IDX_W'(j)]) begin
        lo_found = 1'b1;
        lo_idx   = IDX_W'(j);
      end
    end
  end

  always_comb begin
    pick    = PICK_NONE;
    sel_idx = '0;
    if (ready_i) begin
      if (|cand_hi) begin
        pick    = PICK_HI;
        sel_idx = lowest(cand_hi);
      end else if (lo_found) begin
        pick    = PICK_LO;
        sel_idx = lo_idx;
      end else if (|elig_hi) begin
        pick    = PICK_RESTART;
        sel_idx = lowest(elig_hi);
      end
    end
  end

  assign gnt_valid_o = (pick != PICK_NONE);
  assign gnt_idx_o   = sel_idx;
  assign gnt_o       = gnt_valid_o ? (N_CH'(1) << sel_idx) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      served_q <= '0;
      lo_ptr_q <= IDX_W'(N_CH - 1);
    end else begin
      unique case (pick)
        PICK_HI:      served_q <= served_q | gnt_o;
        PICK_LO: begin
          served_q <= '0;
          lo_ptr_q <= sel_idx;
        end
        PICK_RESTART: served_q <= gnt_o;
        default:      ;
      endcase
    end
  end

  // R9
  grant_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));
  // R8
  grant_elig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o & ~elig_i) == '0);
  // R8
  no_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_i |-> gnt_o == '0);
  // R6
  hi_repeat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_valid_o && |(gnt_o & hi_i) && |elig_lo)
    |=> (!$stable(hi_i) || !(|elig_lo) || gnt_o != $past(gnt_o)));
  // R6
  lo_then_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_valid_o && |(gnt_o & ~hi_i))
    |=> (!ready_i || !$stable(hi_i) || !(|elig_hi) || |(gnt_o & hi_i)));
endmodule

// File: rtl/dma_pace_sched.sv
module dma_pace_sched
  import dma_sched_pkg::*;
#(
  parameter int N_CH    = 8,
  parameter int N_DREQ  = 59,
  parameter int N_TIMER = 4,
  parameter int CNT_W   = 6,
  localparam int IDX_W  = $clog2(N_CH)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [N_DREQ-1:0]     dreq_i,
  input  logic [N_TIMER-1:0]    timer_i,
  input  logic [N_CH-1:0]       ch_en_i,
  input  logic [N_CH-1:0]       ch_hi_i,
  input  logic [N_CH-1:0]       ch_work_i,
  input  logic [N_CH*SEL_W-1:0] ch_sel_i,
  input  logic                  ready_i,
  output logic [N_CH-1:0]       gnt_o,
  output logic [IDX_W-1:0]      gnt_idx_o,
  output logic                  gnt_valid_o
);
  logic [N_CH-1:0] pulse, unpaced, elig;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    dma_pace_decode #(
      .N_DREQ (N_DREQ),
      .N_TIMER(N_TIMER)
    ) u_dec (
      .dreq_i   (dreq_i),
      .timer_i  (timer_i),
      .sel_i    (ch_sel_i[c*SEL_W +: SEL_W]),
      .pulse_o  (pulse[c]),
      .unpaced_o(unpaced[c])
    );

    dma_pace_credit #(
      .CNT_W(CNT_W)
    ) u_cred (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_i     (ch_en_i[c]),
      .work_i   (ch_work_i[c]),
      .pulse_i  (pulse[c]),
      .unpaced_i(unpaced[c]),
      .gnt_i    (gnt_o[c]),
      .elig_o   (elig[c])
    );
  end

  dma_round_arb #(
    .N_CH(N_CH)
  ) u_arb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .elig_i     (elig),
    .hi_i       (ch_hi_i),
    .ready_i    (ready_i),
    .gnt_o      (gnt_o),
    .gnt_idx_o  (gnt_idx_o),
    .gnt_valid_o(gnt_valid_o)
  );

  // R9
  idx_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_valid_o |-> gnt_o == (N_CH'(1) << gnt_idx_o));
  // R5
  disabled_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o & ~ch_en_i) == '0);
  // R10
  no_work_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o & ~ch_work_i) == '0);
endmodule

// File: tb/sim_dma_pace_sched.sv
module sim_dma_pace_sched;
  localparam int N_CH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [58:0] dreq = '0;
  logic [3:0]  tmr = '0;
  logic [7:0]  en = '0, hi = '0, work = '0;
  logic [5:0]  sel [N_CH];
  logic [47:0] sel_flat;
  logic        ready = 1'b0;
  logic [7:0]  gnt0, gnt1;
  logic [2:0]  idx0, idx1;
  logic        vld0, vld1;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  always_comb
    for (int c = 0; c < N_CH; c++) sel_flat[c*6 +: 6] = sel[c];

  dma_pace_sched #(.N_CH(N_CH), .N_DREQ(59), .N_TIMER(4)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .dreq_i(dreq), .timer_i(tmr),
    .ch_en_i(en), .ch_hi_i(hi), .ch_work_i(work), .ch_sel_i(sel_flat),
    .ready_i(ready), .gnt_o(gnt0), .gnt_idx_o(idx0), .gnt_valid_o(vld0));

  // two-timer variant for the absent-timer case
  dma_pace_sched #(.N_CH(N_CH), .N_DREQ(59), .N_TIMER(2)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .dreq_i(dreq), .timer_i(tmr[1:0]),
    .ch_en_i(en), .ch_hi_i(hi), .ch_work_i(work), .ch_sel_i(sel_flat),
    .ready_i(ready), .gnt_o(gnt1), .gnt_idx_o(idx1), .gnt_valid_o(vld1));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    step();
    step();
    rst_n = 1'b1;
  endtask

  task automatic pulse_src(input int s, input bit others);
    logic [63:0] m;
    m = 64'(1) << s;
    if (others) m = ~m;
    dreq = m[58:0];
    tmr  = m[62:59];
  endtask

  initial begin
    int cnt;
    for (int c = 0; c < N_CH; c++) sel[c] = 6'h00;
    do_reset();
    ready = 1'b1;
    #1;
    // R9 reset state
    check(gnt0 == 0 && !vld0, "R9 reset idle", int'(gnt0), 0);
    check(gnt1 == 0 && !vld1, "R9 reset idle u1", int'(gnt1), 0);

    en = 8'h01; work = 8'h01; hi = 8'h00;
    // R1 R2 selector sweep
    for (int s = 0; s < 63; s++) begin
      step(); sel[0] = 6'(s); ready = 1'b0; pulse_src(s, 1'b1);
      step(); dreq = '0; tmr = '0; ready = 1'b1; #1;
      check(gnt0 == 0, (s < 59) ? "R1 foreign line" : "R2 foreign timer", int'(gnt0), 0);
      check(gnt1 == 0, (s < 59) ? "R1 foreign line u1" : "R2 foreign timer u1", int'(gnt1), 0);
      step(); ready = 1'b0; pulse_src(s, 1'b0);
      step(); dreq = '0; tmr = '0; ready = 1'b1; #1;
      check(gnt0 == 8'h01, (s < 59) ? "R1 own line" : "R2 own timer", int'(gnt0), 1);
      check(gnt1 == ((s >= 61) ? 8'h00 : 8'h01), "R2 absent timer u1", int'(gnt1),
            (s >= 61) ? 0 : 1);
      step(); #1;
      check(gnt0 == 0, "R4 credit consumed", int'(gnt0), 0);
    end

    // R4 saturation
    step(); sel[0] = 6'h00; ready = 1'b0; dreq[0] = 1'b1;
    for (int i = 0; i < 69; i++) step();
    dreq = '0; ready = 1'b1;
    cnt = 0;
    for (int i = 0; i < 70; i++) begin
      #1; if (gnt0[0]) cnt++;
      step();
    end
    check(cnt == 63, "R4 saturate at 63", cnt, 63);

    // R5 disabled: pulses ignored, credit held
    ready = 1'b0; dreq[0] = 1'b1;
    step(); step();
    en[0] = 1'b0;
    step(); step(); step();
    dreq = '0; ready = 1'b1; #1;
    check(gnt0 == 0, "R5 disabled no grant", int'(gnt0), 0);
    step(); #1;
    check(gnt0 == 0, "R5 disabled no grant", int'(gnt0), 0);
    en[0] = 1'b1;
    cnt = 0;
    for (int i = 0; i < 8; i++) begin
      #1; if (gnt0[0]) cnt++;
      step();
    end
    check(cnt == 2, "R5 credit kept while paused", cnt, 2);

    // R10 work flag
    ready = 1'b0; dreq[0] = 1'b1;
    step(); dreq = '0; work[0] = 1'b0; ready = 1'b1; #1;
    check(gnt0 == 0, "R10 no work no grant", int'(gnt0), 0);
    step(); work[0] = 1'b1; #1;
    check(gnt0 == 8'h01, "R10 work restored", int'(gnt0), 1);

    // R3 unpaced grants keep stored credit; R8 ready gating
    step(); ready = 1'b0; dreq[0] = 1'b1;
    step(); dreq = '0; sel[0] = 6'h3F; ready = 1'b1;
    for (int i = 0; i < 5; i++) begin
      #1; check(gnt0 == 8'h01, "R3 unpaced every cycle", int'(gnt0), 1);
      step();
    end
    ready = 1'b0; #1;
    check(gnt0 == 0 && !vld0, "R8 no grant without ready", int'(gnt0), 0);
    step(); sel[0] = 6'h00; ready = 1'b1; #1;
    check(gnt0 == 8'h01, "R3 credit untouched", int'(gnt0), 1);
    step(); #1;
    check(gnt0 == 0, "R3 credit then empty", int'(gnt0), 0);

    // R6 rounds: hi 0,1 then one low; R7 rotation over 2..7
    ready = 1'b0; en = '0;
    do_reset();
    for (int c = 0; c < N_CH; c++) sel[c] = 6'h3F;
    en = 8'hFF; work = 8'hFF; hi = 8'h03; ready = 1'b1;
    for (int t = 0; t < 24; t++) begin
      int m, e;
      m = t % 3;
      e = (m == 0) ? 0 : (m == 1) ? 1 : 2 + (t / 3) % 6;
      #1;
      check(vld0 && int'(idx0) == e, (m == 2) ? "R7 low rotation" : "R6 round order",
            int'(idx0), e);
      check(gnt0 == (8'(1) << idx0), "R9 one-hot matches index", int'(gnt0), 1 << e);
      step();
    end
    // R6 no low eligible: high set restarts
    en = 8'h03;
    for (int t = 0; t < 6; t++) begin
      #1; check(vld0 && int'(idx0) == t % 2, "R6 restart high set", int'(idx0), t % 2);
      step();
    end

    // R7 R8 sparse low set, unsaturated: grant every cycle
    ready = 1'b0; en = '0;
    do_reset();
    hi = 8'h00; en = 8'b0110_0100; ready = 1'b1;
    for (int t = 0; t < 9; t++) begin
      int e;
      e = (t % 3 == 0) ? 2 : (t % 3 == 1) ? 5 : 6;
      #1; check(vld0 && int'(idx0) == e, "R7 R8 round-robin low", int'(idx0), e);
      step();
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule